// File: doc/BRIEF.md
# Dual-Axis Paddle Pulse Timer

This block stands in for a two-channel analog game-paddle timer. A digital position value for each axis takes the place of the old resistor-capacitor network. A single trigger strobe from the host starts both channels together. Each axis output goes high on the clock edge that accepts the trigger. It then stays high for a number of clocks set by that axis's position, so host software that counts polling loops until the output drops reads back the position. Two pushbutton inputs are brought into the clock domain through synchronisers and passed straight out.

The position inputs are live levels and have no valid/ready handshake. Each channel captures its position on the clock edge that accepts a trigger, and ignores it at all other times. The block therefore never stalls its source and never asks for back-pressure: the source only has to hold the value steady around the trigger edge. The trigger and the axis outputs are plain control and status pins.

Top module: `paddle_timer_top`

## Requirements
- R1: While reset is asserted and after its release with no trigger, both axis outputs and both button outputs are 0.
- R2: A trigger is accepted on a clock edge that samples `trig_i` = 1 when the previous edge sampled 0. All axis outputs read 1 right after that edge.
- R3: After an accepted trigger with position p (8-bit, unsigned), the axis output stays 1 for exactly (p + 1) × UNIT_CYCLES clock cycles, counted from the accepting edge. It then returns to 0. The default UNIT_CYCLES is 4.
- R4: The pulse width strictly increases with the position value, so a larger position always gives a longer pulse.
- R5: Each channel samples its position only on the accepting edge. A change of `pos_i` while the pulse runs has no effect on that pulse's width.
- R6: Holding `trig_i` high for several cycles counts as one trigger. The pulse ends on time even while `trig_i` is still high, and a new trigger needs `trig_i` to return to 0 first.
- R7: A trigger accepted while an axis output is still 1 restarts that channel from the newly sampled position. The output stays 1 without a gap and falls (p_new + 1) × UNIT_CYCLES cycles after the retriggering edge.
- R8: The two channels time independently. Axis 0 takes its position from `pos_i[7:0]` and drives `axis_o[0]`; axis 1 takes `pos_i[15:8]` and drives `axis_o[1]`.
- R9: Each button output equals the matching button input as sampled two clock edges earlier, through a two-flop synchroniser.
- R10: Once an axis output has fallen, it stays 0 until the next accepted trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger strobe from the host; the rising edge starts both channels |
| pos_i | input | 16 | Axis positions, axis 0 in bits 7:0 and axis 1 in bits 15:8 |
| btn_i | input | 2 | Asynchronous pushbutton levels |
| axis_o | output | 2 | Per-axis timing pulse, 1 while the channel is timing |
| btn_o | output | 2 | Synchronised pushbutton levels |

## Verification
A corrupted down-counter or a wrong reload value shows up at once as a pulse that is too long or too short. The bench measures the width to the exact cycle for many positions, so even an off-by-one is seen on the first pulse. A lost edge-detect history shows up within the held-trigger test: the pulse is either restarted while the trigger is held or never started. A wrong retrigger path shows up in the retrigger test, as a gap in the output or a fall time that follows the old position. Missing or extra synchroniser stages show up as a button output that changes one edge early or one edge late.

// File: rtl/paddle_pkg.sv
package paddle_pkg;
  typedef enum logic {
    CH_IDLE   = 1'b0,
    CH_TIMING = 1'b1
  } ch_state_e;

  function automatic int unsigned span_width(input int unsigned pos_w,
                                             input int unsigned unit);
    return $clog2((2 ** pos_w) * unit) + 1;
  endfunction
endpackage

// File: rtl/paddle_trig_detect.sv
module paddle_trig_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic fire_o
);
  logic trig_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_prev_q <= 1'b0;
    else        trig_prev_q <= trig_i;
  end

  assign fire_o = trig_i & ~trig_prev_q;

  AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o); // R6
endmodule

// File: rtl/paddle_axis_chan.sv
module paddle_axis_chan
  import paddle_pkg::*;
#(
  parameter int unsigned POS_W       = 8,
  parameter int unsigned UNIT_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             busy_o
);
  localparam int unsigned CNT_W = span_width(POS_W, UNIT_CYCLES);

  ch_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  assign reload = (CNT_W'(pos_i) + CNT_W'(1)) * CNT_W'(UNIT_CYCLES) - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
    end else if (fire_i) begin
      state_q <= CH_TIMING;
      cnt_q   <= reload;
    end else if (state_q == CH_TIMING) begin
      if (cnt_q == '0) state_q <= CH_IDLE;
      else             cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = (state_q == CH_TIMING);

  AST_FIRE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> busy_o); // R2
  AST_RISE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(fire_i)); // R10
  AST_FALL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(cnt_q) == '0)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fire_i && cnt_q != '0) |=> (busy_o && cnt_q == $past(cnt_q) - CNT_W'(1))); // R5
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cnt_q == '0)); // R10
endmodule

// File: rtl/paddle_btn_sync.sv
module paddle_btn_sync #(
  parameter int unsigned BTN_W  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BTN_W-1:0] btn_i,
  output logic [BTN_W-1:0] btn_o
);
  logic [BTN_W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= btn_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign btn_o = stage_q[STAGES-1];

  AST_BTN_FROM_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(btn_o) |-> (btn_o == $past(stage_q[0]))); // R9
endmodule

// File: rtl/paddle_timer_top.sv
module paddle_timer_top #(
  parameter int unsigned NUM_AXES    = 2,
  parameter int unsigned POS_W       = 8,
  parameter int unsigned UNIT_CYCLES = 4,
  parameter int unsigned NUM_BTN     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      trig_i,
  input  logic [NUM_AXES*POS_W-1:0] pos_i,
  input  logic [NUM_BTN-1:0]        btn_i,
  output logic [NUM_AXES-1:0]       axis_o,
  output logic [NUM_BTN-1:0]        btn_o
);
  logic fire;

  paddle_trig_detect u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_i),
    .fire_o (fire)
  );

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    paddle_axis_chan #(
      .POS_W       (POS_W),
      .UNIT_CYCLES (UNIT_CYCLES)
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (fire),
      .pos_i  (pos_i[a*POS_W +: POS_W]),
      .busy_o (axis_o[a])
    );
  end

  paddle_btn_sync #(
    .BTN_W  (NUM_BTN),
    .STAGES (SYNC_STAGES)
  ) u_btn (
    .clk   (clk),
    .rst_n (rst_n),
    .btn_i (btn_i),
    .btn_o (btn_o)
  );

  AST_FIRE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (axis_o == {NUM_AXES{1'b1}})); // R2
endmodule

// File: tb/sim_paddle_timer_top.sv
module sim_paddle_timer_top;
  localparam int UNIT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_i = 1'b0;
  logic [15:0] pos_i = '0;
  logic [1:0]  btn_i = '0;
  logic [1:0]  axis_o;
  logic [1:0]  btn_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  paddle_timer_top u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .pos_i(pos_i),
    .btn_i(btn_i), .axis_o(axis_o), .btn_o(btn_o)
  );

  // each entry: {pos axis1, pos axis0}
  localparam logic [15:0] VEC [7] = '{
    16'h0000, 16'hFF00, 16'h0201, 16'h0102, 16'h2564, 16'hFFFF, 16'h0A0A
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Trigger at a negedge; afterwards count negedge samples with each axis high.
  task automatic run_pulse(input logic [15:0] p, output int w0, output int w1);
    @(negedge clk);
    pos_i = p; trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    w0 = 0; w1 = 0;
    for (int i = 0; i < 2000; i++) begin
      if (axis_o == 2'b00) break;
      if (axis_o[0]) w0++;
      if (axis_o[1]) w1++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w0, w1, gaps;
    repeat (3) @(negedge clk);
    check("R1 axis in reset", axis_o, 0);
    check("R1 btn in reset", btn_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 axis idle", axis_o, 0);

    // Table walk: R3, R8
    for (int v = 0; v < 7; v++) begin
      run_pulse(VEC[v], w0, w1);
      check("R3/R8 axis0 width", w0, (int'(VEC[v][7:0]) + 1) * UNIT);
      check("R3/R8 axis1 width", w1, (int'(VEC[v][15:8]) + 1) * UNIT);
      if (v == 2) check("R4 larger pos longer", int'(w1 > w0), 1);
      if (v == 3) check("R4 larger pos longer", int'(w0 > w1), 1);
    end

    // R10: stays low with no trigger
    repeat (20) @(negedge clk);
    check("R10 stays low", axis_o, 0);

    // R2: high right after the accepting edge
    @(negedge clk); pos_i = 16'h0505; trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
    check("R2 both high after edge", axis_o, 3);
    repeat (40) @(negedge clk);

    // R5: change pos mid-pulse
    @(negedge clk); pos_i = 16'h0303; trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
    w0 = 0;
    for (int i = 0; i < 2000; i++) begin
      if (i == 2) pos_i = 16'hC8C8;
      if (!axis_o[0]) break;
      w0++;
      @(negedge clk);
    end
    check("R5 width ignores mid change", w0, 4 * UNIT);

    // R6: trigger held high for 30 cycles, pos 1 -> 8 cycles
    @(negedge clk); pos_i = 16'h0101; trig_i = 1'b1;
    w0 = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (axis_o[0]) w0++;
    end
    check("R6 held trigger one pulse", w0, 2 * UNIT);
    check("R6 low while held", axis_o, 0);
    trig_i = 1'b0;
    @(negedge clk);
    run_pulse(16'h0000, w0, w1);
    check("R6 retrigger after low", w0, UNIT);

    // R7: retrigger while high
    @(negedge clk); pos_i = 16'h0A0A; trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
    gaps = 0;
    repeat (5) begin
      if (axis_o != 2'b11) gaps++;
      @(negedge clk);
    end
    pos_i = 16'h0201; trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
    w0 = 0; w1 = 0;
    for (int i = 0; i < 2000; i++) begin
      if (axis_o == 2'b00) break;
      if (axis_o[0]) w0++;
      if (axis_o[1]) w1++;
      @(negedge clk);
    end
    check("R7 no gap before retrigger", gaps, 0);
    check("R7 axis0 restart width", w0, 2 * UNIT);
    check("R7 axis1 restart width", w1, 3 * UNIT);

    // R9: two-edge synchroniser
    @(negedge clk); btn_i = 2'b10;
    @(negedge clk);
    check("R9 not after one edge", btn_o, 0);
    @(negedge clk);
    check("R9 after two edges", btn_o, 2);
    btn_i = 2'b01;
    @(negedge clk);
    check("R9 old value held", btn_o, 2);
    @(negedge clk);
    check("R9 new value", btn_o, 1);
    check("R8 buttons leave axes idle", axis_o, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule